// File: doc/BRIEF.md
# Four-Instruction Single-Cycle Integer Core

This block is a small processor that executes a subset of the 32-bit RISC-V integer instructions: byte load, byte store, register add and register exclusive-or. Every instruction is completed within one clock: the word is fetched from an external instruction ROM, decoded, run through the ALU, given its data-memory access and written back before the next edge. Because nothing is in flight across clock edges, an instruction may use the result of the one before it with no stall or forwarding.

The program counter counts whole instruction words from zero. The length of the program is supplied on an input. When the counter reaches that length the core stops, holds its state and raises `halt`. The data memory is internal and one byte wide per cell. A side port lets the environment preload bytes before a run and read any byte back afterwards. Loads and stores move single bytes, so byte order never enters the design.

Top module: `scc_core`

## Requirements
- R1: While reset is active and after it, all 32 general registers read zero until an instruction writes them. During reset, `imem_addr` is 0.
- R2: Register 0 always reads zero. A load or add that names it as the destination leaves it zero.
- R3: A byte load (opcode 0000011, funct3 000) sign-extends bit 7 of the byte into bits 31:8 of the destination register.
- R4: A byte store (opcode 0100011, funct3 000) writes only bits 7:0 of the rs2 register into exactly one memory byte and leaves the neighbouring bytes unchanged.
- R5: ADD (opcode 0110011, funct3 000, funct7 0000000) writes rs1 + rs2 modulo 2^32 to rd.
- R6: XOR (opcode 0110011, funct3 100, funct7 0000000) writes the bitwise exclusive-or of rs1 and rs2 to rd. XOR of a register with itself clears the destination.
- R7: The load offset is instr[31:20], and the store offset is instr[31:25] joined above instr[11:7]. Both are sign-extended, and the effective address is rs1 plus the offset.
- R8: Any other opcode, or any other funct3/funct7 combination, writes neither a register nor memory.
- R9: After reset is released, the program counter advances by one word per clock. `halt` is high exactly when the counter is at least `prog_len`. The counter then stays where it is, and no further instruction has any effect.
- R10: With bytes 0 and 1 preloaded to 123 and 99, the five-word reference program (xor r1,r1,r1; lb r2,0(r1); lb r3,1(r1); add r3,r2,r3; sb r3,3(r1)) leaves r2=123, r3=222 and byte 3=222, and changes nothing else. A load followed at once by an add that uses its result needs no stall.
- R11: An effective address at or above the memory depth is out of range. A store there is dropped, and a load from there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | IMEM_AW | Word index of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| prog_len | input | IMEM_AW+1 | Number of instructions in the program |
| halt | output | 1 | High once the program counter has reached `prog_len` |
| dbg_we | input | 1 | Side-port byte write strobe |
| dbg_addr | input | log2(DMEM_DEPTH) | Side-port byte address |
| dbg_wdata | input | 8 | Side-port write byte |
| dbg_rdata | output | 8 | Byte at `dbg_addr`, combinational |

## Verification
Register contents cannot be seen from the ports. Every register check therefore goes through the data path itself: a program stores the register of interest with a byte store, and the bench reads that byte back through the side port. Sign extension of a loaded byte is the hardest case, because a byte store discards exactly the bits in question. The bench reaches them through addressing instead. It uses the loaded value as a base with a small offset, so a sign-extended value lands on an in-range byte and a zero-extended value lands out of range, where the store is dropped. Each store target is preloaded with a distinct marker, so a dropped or misdirected write is visible.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_N  = 32;
  localparam int REG_AW = $clog2(REG_N);

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_BYTE   = 3'b000;
  localparam logic [2:0] F3_ADD    = 3'b000;
  localparam logic [2:0] F3_XOR    = 3'b100;
  localparam logic [6:0] F7_BASE   = 7'b0000000;

  typedef enum logic {ALU_ADD = 1'b0, ALU_XOR = 1'b1} alu_op_e;

  typedef struct packed {
    logic              rf_we;
    logic              is_load;
    logic              is_store;
    logic              use_imm;
    logic              illegal;
    alu_op_e           alu_op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [XLEN-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/scc_decode.sv
module scc_decode
  import scc_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [XLEN-1:0] imm_i;
  logic [XLEN-1:0] imm_s;

  assign opc   = instr[6:0];
  assign f3    = instr[14:12];
  assign f7    = instr[31:25];
  assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};

  always_comb begin
    dec          = '0;
    dec.rd       = instr[11:7];
    dec.rs1      = instr[19:15];
    dec.rs2      = instr[24:20];
    dec.alu_op   = ALU_ADD;
    dec.illegal  = 1'b1;
    unique case (opc)
      OPC_REG: begin
        if (f7 == F7_BASE && f3 == F3_ADD) begin
          dec.rf_we   = 1'b1;
          dec.illegal = 1'b0;
        end else if (f7 == F7_BASE && f3 == F3_XOR) begin
          dec.rf_we   = 1'b1;
          dec.alu_op  = ALU_XOR;
          dec.illegal = 1'b0;
        end
      end
      OPC_LOAD: begin
        if (f3 == F3_BYTE) begin
          dec.rf_we   = 1'b1;
          dec.is_load = 1'b1;
          dec.use_imm = 1'b1;
          dec.imm     = imm_i;
          dec.illegal = 1'b0;
        end
      end
      OPC_STORE: begin
        if (f3 == F3_BYTE) begin
          dec.is_store = 1'b1;
          dec.use_imm  = 1'b1;
          dec.imm      = imm_s;
          dec.illegal  = 1'b0;
        end
      end
      default: dec.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [REG_AW-1:0] raddr_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [REG_N*XLEN-1:0] flat;

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign flat[g*XLEN +: XLEN] = '0;
    end else begin : g_store
      logic            en;
      logic [XLEN-1:0] q;
      assign en = we && (waddr == REG_AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata;
      end
      assign flat[g*XLEN +: XLEN] = q;
    end
  end

  assign rdata_a = flat[raddr_a*XLEN +: XLEN];
  assign rdata_b = flat[raddr_b*XLEN +: XLEN];
endmodule

// File: rtl/scc_dmem.sv
module scc_dmem #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [7:0]    core_wdata,
  output logic [7:0]    core_rdata,
  input  logic          side_we,
  input  logic [AW-1:0] side_addr,
  input  logic [7:0]    side_wdata,
  output logic [7:0]    side_rdata
);
  logic [DEPTH*8-1:0] flat;

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic       hit_core;
    logic       hit_side;
    logic       en;
    logic [7:0] d;
    logic [7:0] q;
    assign hit_core = core_we && (core_addr == AW'(c));
    assign hit_side = side_we && (side_addr == AW'(c));
    assign en       = hit_core || hit_side;
    assign d        = hit_core ? core_wdata : side_wdata;
    always_ff @(posedge clk) begin
      if (en) q <= d;
    end
    assign flat[c*8 +: 8] = q;
  end

  assign core_rdata = flat[core_addr*8 +: 8];
  assign side_rdata = flat[side_addr*8 +: 8];
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int IMEM_AW    = 8,
  parameter int DMEM_DEPTH = 64,
  localparam int DM_AW     = $clog2(DMEM_DEPTH),
  localparam int PC_W      = IMEM_AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_data,
  input  logic [PC_W-1:0]    prog_len,
  output logic               halt,
  input  logic               dbg_we,
  input  logic [DM_AW-1:0]   dbg_addr,
  input  logic [7:0]         dbg_wdata,
  output logic [7:0]         dbg_rdata
);
  // reset release synchroniser
  logic rst_s1;
  logic rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  // program counter
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] pc_nxt;
  logic            run;
  logic            pc_en;

  assign halt  = (pc >= prog_len);
  assign run   = rst_q && !halt;
  assign pc_en = run;

  always_comb begin
    pc_nxt = pc;
    if (pc_en) pc_nxt = pc + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     pc <= '0;
    else if (pc_en) pc <= pc_nxt;
  end

  assign imem_addr = pc[IMEM_AW-1:0];

  // decode
  dec_t dec;
  scc_decode u_dec (
    .instr (imem_data),
    .dec   (dec)
  );

  // register file
  logic [XLEN-1:0] rs1_val;
  logic [XLEN-1:0] rs2_val;
  logic [XLEN-1:0] wb_val;
  logic            rf_we;

  scc_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (rf_we),
    .waddr   (dec.rd),
    .wdata   (wb_val),
    .raddr_a (dec.rs1),
    .raddr_b (dec.rs2),
    .rdata_a (rs1_val),
    .rdata_b (rs2_val)
  );

  // ALU and address
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;
  logic            in_range;

  assign opnd_b = dec.use_imm ? dec.imm : rs2_val;

  always_comb begin
    unique case (dec.alu_op)
      ALU_XOR: alu_y = rs1_val ^ opnd_b;
      default: alu_y = rs1_val + opnd_b;
    endcase
  end

  assign in_range = (alu_y < XLEN'(DMEM_DEPTH));

  // data memory
  logic [7:0]       ld_byte;
  logic [7:0]       ld_raw;
  logic             dm_we;
  logic [DM_AW-1:0] dm_addr;

  assign dm_addr = alu_y[DM_AW-1:0];
  assign dm_we   = run && dec.is_store && in_range;

  scc_dmem #(.DEPTH(DMEM_DEPTH)) u_dm (
    .clk        (clk),
    .core_we    (dm_we),
    .core_addr  (dm_addr),
    .core_wdata (rs2_val[7:0]),
    .core_rdata (ld_raw),
    .side_we    (dbg_we),
    .side_addr  (dbg_addr),
    .side_wdata (dbg_wdata),
    .side_rdata (dbg_rdata)
  );

  assign ld_byte = in_range ? ld_raw : 8'h00;

  // write back
  assign wb_val = dec.is_load ? {{(XLEN-8){ld_byte[7]}}, ld_byte} : alu_y;
  assign rf_we  = run && dec.rf_we;
endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk
  import scc_pkg::*;
#(
  parameter int IMEM_AW    = 8,
  parameter int DMEM_DEPTH = 64,
  localparam int PC_W      = IMEM_AW + 1
) (
  input logic              clk,
  input logic              rst_q,
  input logic [PC_W-1:0]   pc,
  input logic              halt,
  input logic              rf_we,
  input logic              dm_we,
  input logic [XLEN-1:0]   alu_y,
  input dec_t              dec,
  input logic [XLEN-1:0]   rs1_val
);
  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !halt |=> pc == $past(pc) + PC_W'(1));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    halt |=> $stable(pc));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    halt |-> !rf_we && !dm_we);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dec.illegal |-> !rf_we && !dm_we);
  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dec.rs1 == '0 |-> rs1_val == '0);
  // R11
  store_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dm_we |-> alu_y < XLEN'(DMEM_DEPTH));
endmodule

bind scc_core scc_core_chk #(.IMEM_AW(IMEM_AW), .DMEM_DEPTH(DMEM_DEPTH)) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .pc      (pc),
  .halt    (halt),
  .rf_we   (rf_we),
  .dm_we   (dm_we),
  .alu_y   (alu_y),
  .dec     (dec),
  .rs1_val (rs1_val)
);

// File: tb/scc_core_tb.sv
module scc_core_tb;
  localparam int IMEM_AW = 8;
  localparam int DEPTH   = 64;
  localparam int DM_AW   = $clog2(DEPTH);
  localparam int ROM_N   = 16;

  logic               clk;
  logic               rst_n;
  logic [IMEM_AW-1:0] imem_addr;
  logic [31:0]        imem_data;
  logic [IMEM_AW:0]   prog_len;
  logic               halt;
  logic               dbg_we;
  logic [DM_AW-1:0]   dbg_addr;
  logic [7:0]         dbg_wdata;
  logic [7:0]         dbg_rdata;

  logic [31:0] rom [ROM_N];
  int checks;
  int fails;
  int cyc;

  scc_core #(.IMEM_AW(IMEM_AW), .DMEM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .prog_len(prog_len), .halt(halt), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  assign imem_data = (imem_addr < IMEM_AW'(ROM_N)) ? rom[imem_addr[3:0]] : 32'h0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_add(input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b);
    return e_r(7'b0, b, a, 3'b000, rd);
  endfunction
  function automatic logic [31:0] e_xor(input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b);
    return e_r(7'b0, b, a, 3'b100, rd);
  endfunction
  function automatic logic [31:0] e_lb(input logic [4:0] rd, input logic [4:0] rs1, input int imm);
    logic [11:0] i;
    i = imm[11:0];
    return {i, rs1, 3'b000, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] e_sb(input logic [4:0] rs2, input logic [4:0] rs1, input int imm);
    logic [11:0] i;
    i = imm[11:0];
    return {i[11:5], rs2, rs1, 3'b000, i[4:0], 7'b0100011};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = DM_AW'(a); dbg_wdata = v;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    dbg_addr = DM_AW'(a);
    #1;
    v = dbg_rdata;
  endtask

  task automatic expect_byte(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    peek(a, v);
    check(v === exp, req, int'(v), int'(exp));
  endtask

  task automatic setup();
    @(negedge clk);
    rst_n = 1'b0;
    prog_len = '0;
    for (int i = 0; i < ROM_N; i++) rom[i] = 32'h0;
    for (int i = 0; i < DEPTH; i++) poke(i, 8'h00);
  endtask

  task automatic go(input int len, output int n);
    prog_len = (IMEM_AW+1)'(len);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halt && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(halt === 1'b1, "R9 halt reached", int'(halt), 1);
  endtask

  task automatic t_reset_state();
    int n;
    setup();
    prog_len = 9'd5;
    #1;
    check(imem_addr == '0, "R1 pc zero in reset", int'(imem_addr), 0);
    check(halt === 1'b0, "R9 no halt in reset", int'(halt), 0);
    poke(0, 8'hAA); poke(1, 8'hAA); poke(2, 8'hAA);
    rom[0] = e_sb(5'd2, 5'd0, 0);
    rom[1] = e_sb(5'd3, 5'd0, 1);
    rom[2] = e_sb(5'd31, 5'd0, 2);
    go(3, n);
    expect_byte(0, 8'h00, "R1 r2 cleared");
    expect_byte(1, 8'h00, "R1 r3 cleared");
    expect_byte(2, 8'h00, "R1 r31 cleared");
  endtask

  task automatic t_reference();
    int n;
    setup();
    poke(0, 8'd123); poke(1, 8'd99);
    rom[0] = 32'b00000000000100001100000010110011;
    rom[1] = 32'b00000000000000001000000100000011;
    rom[2] = 32'b00000000000100001000000110000011;
    rom[3] = 32'b00000000001100010000000110110011;
    rom[4] = 32'b00000000001100001000000110100011;
    rom[5] = e_sb(5'd2, 5'd0, 8);
    rom[6] = e_sb(5'd3, 5'd0, 9);
    rom[7] = e_sb(5'd1, 5'd0, 10);
    go(8, n);
    expect_byte(3, 8'd222, "R10 byte3");
    expect_byte(0, 8'd123, "R10 byte0 kept");
    expect_byte(1, 8'd99, "R10 byte1 kept");
    expect_byte(2, 8'd0, "R10 byte2 kept");
    expect_byte(4, 8'd0, "R10 byte4 kept");
    expect_byte(8, 8'd123, "R10 r2");
    expect_byte(9, 8'd222, "R10 r3");
    expect_byte(10, 8'd0, "R10 r1");
  endtask

  task automatic t_zero_reg();
    int n;
    setup();
    poke(0, 8'h55); poke(4, 8'h77); poke(5, 8'h77);
    rom[0] = e_lb(5'd0, 5'd0, 0);
    rom[1] = e_sb(5'd0, 5'd0, 4);
    rom[2] = e_lb(5'd1, 5'd0, 0);
    rom[3] = e_add(5'd0, 5'd1, 5'd1);
    rom[4] = e_sb(5'd0, 5'd0, 5);
    go(5, n);
    expect_byte(4, 8'h00, "R2 x0 after load");
    expect_byte(5, 8'h00, "R2 x0 after add");
  endtask

  task automatic t_sign_range();
    int n;
    setup();
    poke(0, 8'hFF); poke(1, 8'h7F); poke(2, 8'h33); poke(3, 8'h44);
    poke(8, 8'h99); poke(9, 8'h66);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_lb(5'd2, 5'd0, 1);
    rom[2] = e_lb(5'd3, 5'd0, 2);
    rom[3] = e_lb(5'd4, 5'd0, 3);
    rom[4] = e_sb(5'd3, 5'd1, 5);
    rom[5] = e_sb(5'd4, 5'd2, 5);
    rom[6] = e_lb(5'd5, 5'd0, 200);
    rom[7] = e_sb(5'd5, 5'd0, 9);
    go(8, n);
    expect_byte(4, 8'h33, "R3 sign-extended base");
    expect_byte(5, 8'h00, "R11 dropped store no alias");
    expect_byte(9, 8'h00, "R11 out-of-range load zero");
    expect_byte(8, 8'h99, "R11 byte kept");
  endtask

  task automatic t_alu();
    int n;
    setup();
    poke(0, 8'hF0); poke(1, 8'h3C);
    poke(10, 8'hEE); poke(11, 8'hEE); poke(12, 8'hEE);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_lb(5'd2, 5'd0, 1);
    rom[2] = e_add(5'd3, 5'd1, 5'd2);
    rom[3] = e_xor(5'd4, 5'd1, 5'd2);
    rom[4] = e_xor(5'd5, 5'd1, 5'd1);
    rom[5] = e_sb(5'd3, 5'd0, 10);
    rom[6] = e_sb(5'd4, 5'd0, 11);
    rom[7] = e_sb(5'd5, 5'd0, 12);
    go(8, n);
    expect_byte(10, 8'h2C, "R5 add");
    expect_byte(11, 8'hCC, "R6 xor");
    expect_byte(12, 8'h00, "R6 xor self");
  endtask

  task automatic t_store_low();
    int n;
    setup();
    poke(0, 8'h81); poke(19, 8'h5A); poke(20, 8'h5A); poke(21, 8'h5A);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_sb(5'd1, 5'd0, 20);
    go(2, n);
    expect_byte(20, 8'h81, "R4 low byte");
    expect_byte(19, 8'h5A, "R4 below kept");
    expect_byte(21, 8'h5A, "R4 above kept");
  endtask

  task automatic t_offsets();
    int n;
    setup();
    poke(0, 8'h0A); poke(7, 8'h42);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_lb(5'd2, 5'd1, -3);
    rom[2] = e_sb(5'd2, 5'd0, 37);
    rom[3] = e_sb(5'd2, 5'd1, -10);
    go(4, n);
    expect_byte(37, 8'h42, "R7 split store offset");
    expect_byte(5, 8'h00, "R7 high field used");
    expect_byte(0, 8'h42, "R7 negative offsets");
  endtask

  task automatic t_illegal();
    int n;
    setup();
    poke(0, 8'h11); poke(30, 8'hEE); poke(31, 8'hEE);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_r(7'b0100000, 5'd1, 5'd1, 3'b000, 5'd1);
    rom[2] = {12'd5, 5'd0, 3'b000, 5'd1, 7'b0010011};
    rom[3] = {12'd0, 5'd0, 3'b010, 5'd1, 7'b0000011};
    rom[4] = {7'd0, 5'd1, 5'd0, 3'b010, 5'd30, 7'b0100011};
    rom[5] = e_r(7'b0000000, 5'd1, 5'd1, 3'b001, 5'd1);
    rom[6] = e_sb(5'd1, 5'd0, 31);
    go(7, n);
    expect_byte(31, 8'h11, "R8 register untouched");
    expect_byte(30, 8'hEE, "R8 memory untouched");
  endtask

  task automatic t_halt();
    int n;
    setup();
    poke(0, 8'h5C);
    rom[0] = e_lb(5'd1, 5'd0, 0);
    rom[1] = e_sb(5'd1, 5'd0, 1);
    rom[2] = e_sb(5'd1, 5'd0, 2);
    go(2, n);
    check(n == 4, "R9 cycles to halt", n, 4);
    check(imem_addr == 8'd2, "R9 pc at length", int'(imem_addr), 2);
    repeat (5) @(negedge clk);
    check(halt === 1'b1 && imem_addr == 8'd2, "R9 pc held", int'(imem_addr), 2);
    expect_byte(1, 8'h5C, "R9 last instruction ran");
    expect_byte(2, 8'h00, "R9 past end not run");
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    rst_n = 1'b0; prog_len = '0;
    dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    for (int i = 0; i < ROM_N; i++) rom[i] = 32'h0;
    t_reference();
    t_reset_state();
    t_zero_reg();
    t_sign_range();
    t_alu();
    t_store_low();
    t_offsets();
    t_illegal();
    t_halt();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule